// File: doc/BRIEF.md
# Privileged-Operation and Illegal-Instruction Trap Entry

This block sits beside the issue stage of a processor core and sees every decoded instruction once. For each one it decides whether the instruction may proceed, whether it must be diverted into a program interrupt, or whether it stops the core. Its inputs are the instruction's operation class, the most significant bit of its special-register number, an illegal-instruction flag from the decoder, the current instruction address, and the current machine state word. It updates the next instruction address, the two save/restore registers, a registered copy of the machine state word, and a sticky halt flag.

A privileged instruction that arrives while the machine state word says problem (user) state is not executed. Instead the block performs a single-cycle trap entry. The same happens to an illegal instruction, whatever the state. Both causes use one fixed vector. The save/restore registers capture the faulting address and the old state word, and a cause bit is set in the saved copy. The live state word is forced into a fixed supervisor, 64-bit, little-endian configuration. An attention instruction in supervisor state freezes the block: every later instruction is ignored until reset.

Top module: `priv_trap_unit`

## Requirements
- R1: While rst_ni is low, all registered outputs (nia_o, srr0_o, srr1_o, msr_o) are zero, and trap_o and halted_o are 0.
- R2: The operation classes read-state (op 1), write-state (op 2), write-state-doubleword (op 3), return-from-interrupt (op 4) and attention (op 5) are privileged. When one of them is accepted with the problem-state bit msr_i[14] equal to 1, the next cycle shows trap_o=1 and nia_o=TRAP_VEC (default 0x700).
- R3: The special-register move classes (op 6 read, op 7 write) are privileged only when spr_msb_i=1. With spr_msb_i=0 and msr_i[14]=1 they do not trap, and nia_o becomes cia_i+4.
- R4: A privileged class accepted with msr_i[14]=0 does not trap. Attention is the exception, covered by R8. Such an instruction gives nia_o=cia_i+4 and leaves srr0_o and srr1_o unchanged.
- R5: On trap entry, srr0_o takes cia_i and srr1_o takes msr_i, with the cause bit set. For a privileged-operation cause the bit is PRIV_BIT (default 18).
- R6: An accepted instruction with illegal_i=1 traps, setting ILLEG_BIT (default 19) in srr1_o. If the instruction is also a privileged one in problem state, the privileged cause wins, and only PRIV_BIT is added.
- R7: On trap entry, msr_o equals msr_i with these bits cleared: 32, 25, 23, 15, 14, 13, 11, 10, 9, 8, 5, 4, 2 and 1. Bits 63 and 0 are set, and all other bits are kept.
- R8: Attention (op 5) accepted with msr_i[14]=0 sets halted_o. nia_o, msr_o, srr0_o and srr1_o keep their values. From then on, until reset, accepted instructions change nothing and trap_o stays 0.
- R9: A non-trapping, non-halting accepted instruction gives trap_o=0, msr_o=msr_i and nia_o=cia_i+4, and leaves srr0_o and srr1_o unchanged.
- R10: While valid_i=0, no output changes, except that trap_o returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A decoded instruction is presented this cycle |
| op_class_i | input | 3 | Operation class (0 other, 1..7 as in R2/R3) |
| spr_msb_i | input | 1 | Most significant bit of the special-register number |
| illegal_i | input | 1 | Decoder found no valid instruction |
| cia_i | input | 64 | Current instruction address |
| msr_i | input | 64 | Current machine state word |
| nia_o | output | 64 | Next instruction address |
| srr0_o | output | 64 | Saved address register |
| srr1_o | output | 64 | Saved state register with cause bit |
| msr_o | output | 64 | Machine state word after this instruction |
| trap_o | output | 1 | Trap entry happened on the last accepted instruction |
| halted_o | output | 1 | Sticky halt after supervisor attention |

## Verification
Every decision is registered in the cycle after acceptance. A wrong classification therefore appears one edge later, as a wrong trap_o together with nia_o, which holds either the vector or cia_i+4. A wrong cause or a wrong forcing mask shows up at that same edge as a mismatched bit in srr1_o or msr_o. A halt flag that leaks or fails to stick shows up on the very next accepted instruction, because nia_o or the save registers then move when they should not.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  localparam int XLEN = 64;

  typedef enum logic [2:0] {
    OPC_OTHER  = 3'd0,
    OPC_MFST   = 3'd1,
    OPC_MTST   = 3'd2,
    OPC_MTSTD  = 3'd3,
    OPC_RETI   = 3'd4,
    OPC_ATTN   = 3'd5,
    OPC_SPRRD  = 3'd6,
    OPC_SPRWR  = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_PRIV  = 2'd1,
    CAUSE_ILLEG = 2'd2
  } cause_e;

  // state-word bit positions, LSB = 0
  localparam int ST_PROB = 14;
  localparam int N_CLR = 14;
  localparam int N_SET = 2;
  localparam int CLR_POS [N_CLR] = '{32, 25, 23, 15, 14, 13, 11, 10, 9, 8, 5, 4, 2, 1};
  localparam int SET_POS [N_SET] = '{63, 0};

  function automatic logic [XLEN-1:0] clr_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < N_CLR; i++) m[CLR_POS[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] set_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < N_SET; i++) m[SET_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/priv_trap_classify.sv
module priv_trap_classify
  import priv_trap_pkg::*;
(
  input  op_class_e op_i,
  input  logic      spr_msb_i,
  input  logic      illegal_i,
  input  logic      prob_i,
  output cause_e    cause_o,
  output logic      halt_req_o
);
  logic is_priv;

  always_comb begin
    unique case (op_i)
      OPC_MFST, OPC_MTST, OPC_MTSTD, OPC_RETI, OPC_ATTN: is_priv = 1'b1;
      OPC_SPRRD, OPC_SPRWR:                              is_priv = spr_msb_i;
      default:                                           is_priv = 1'b0;
    endcase
  end

  // priority: privilege fault, then supervisor halt, then illegal
  always_comb begin
    halt_req_o = 1'b0;
    if (is_priv && prob_i) begin
      cause_o = CAUSE_PRIV;
    end else if (op_i == OPC_ATTN) begin
      cause_o    = CAUSE_NONE;
      halt_req_o = 1'b1;
    end else if (illegal_i) begin
      cause_o = CAUSE_ILLEG;
    end else begin
      cause_o = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/priv_trap_state_build.sv
module priv_trap_state_build
  import priv_trap_pkg::*;
#(
  parameter int PRIV_BIT  = 18,
  parameter int ILLEG_BIT = 19
) (
  input  logic [XLEN-1:0] msr_i,
  input  cause_e          cause_i,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_forced_o
);
  localparam logic [XLEN-1:0] CLR_M = clr_mask();
  localparam logic [XLEN-1:0] SET_M = set_mask();

  logic [XLEN-1:0] cause_m;

  always_comb begin
    cause_m = '0;
    if (cause_i == CAUSE_PRIV)  cause_m[PRIV_BIT]  = 1'b1;
    if (cause_i == CAUSE_ILLEG) cause_m[ILLEG_BIT] = 1'b1;
  end

  assign srr1_o       = msr_i | cause_m;
  assign msr_forced_o = (msr_i & ~CLR_M) | SET_M;
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import priv_trap_pkg::*;
#(
  parameter logic [XLEN-1:0] TRAP_VEC = 64'h700,
  parameter int PRIV_BIT  = 18,
  parameter int ILLEG_BIT = 19
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_class_i,
  input  logic            spr_msb_i,
  input  logic            illegal_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] nia_o,
  output logic [XLEN-1:0] srr0_o,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_o,
  output logic            trap_o,
  output logic            halted_o
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  cause_e          cause;
  logic            halt_req;
  logic [XLEN-1:0] srr1_val, msr_forced;
  logic            accept;

  priv_trap_classify u_classify (
    .op_i       (op_class_e'(op_class_i)),
    .spr_msb_i  (spr_msb_i),
    .illegal_i  (illegal_i),
    .prob_i     (msr_i[ST_PROB]),
    .cause_o    (cause),
    .halt_req_o (halt_req)
  );

  priv_trap_state_build #(
    .PRIV_BIT  (PRIV_BIT),
    .ILLEG_BIT (ILLEG_BIT)
  ) u_build (
    .msr_i        (msr_i),
    .cause_i      (cause),
    .srr1_o       (srr1_val),
    .msr_forced_o (msr_forced)
  );

  assign accept = valid_i && !halted_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nia_o    <= '0;
      srr0_o   <= '0;
      srr1_o   <= '0;
      msr_o    <= '0;
      trap_o   <= 1'b0;
      halted_o <= 1'b0;
    end else begin
      trap_o <= 1'b0;
      if (accept) begin
        if (cause != CAUSE_NONE) begin
          srr0_o <= cia_i;
          srr1_o <= srr1_val;
          msr_o  <= msr_forced;
          nia_o  <= TRAP_VEC;
          trap_o <= 1'b1;
        end else if (halt_req) begin
          halted_o <= 1'b1;
        end else begin
          msr_o <= msr_i;
          nia_o <= cia_i + INSN_BYTES;
        end
      end
    end
  end

  p_vector_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> nia_o == TRAP_VEC);
  p_save_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_o) |-> srr0_o == $past(cia_i));
  p_forced_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (msr_o[63] && msr_o[0] && !msr_o[ST_PROB]));
  p_halt_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && !trap_o);
  p_halt_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(nia_o) && $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(nia_o) && $stable(srr1_o) && !trap_o);
endmodule

// File: tb/priv_trap_unit_bench.sv
module priv_trap_unit_bench;
  localparam int NV = 13;
  localparam logic [63:0] PR = 64'h4000;
  localparam logic [63:0] CLRM = 64'h0000_0001_0280_EF36;
  localparam logic [63:0] SETM = 64'h8000_0000_0000_0001;

  typedef struct packed {
    logic [2:0]  op;
    logic        msb;
    logic        ill;
    logic [63:0] cia;
    logic [63:0] msr;
    logic [1:0]  kind; // 0 none, 1 privileged cause, 2 illegal cause
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 64'h1000, PR,                       2'd0}, // R9
    '{3'd1, 1'b0, 1'b0, 64'h1004, 64'hA000_0000_0000_4000,  2'd1}, // R2
    '{3'd2, 1'b0, 1'b0, 64'h2000, 64'h8000_0000_0000_0020,  2'd0}, // R4
    '{3'd3, 1'b0, 1'b0, 64'h2004, 64'h0000_0001_0000_4030,  2'd1}, // R2
    '{3'd4, 1'b0, 1'b0, 64'h2008, 64'h0000_0000_0280_4000,  2'd1}, // R2
    '{3'd6, 1'b0, 1'b0, 64'h3000, PR,                       2'd0}, // R3
    '{3'd7, 1'b1, 1'b0, 64'h3004, 64'h0000_0000_0000_E000,  2'd1}, // R3
    '{3'd6, 1'b1, 1'b0, 64'h3008, 64'h0000_0000_0000_0800,  2'd0}, // R4
    '{3'd0, 1'b0, 1'b1, 64'h4000, 64'h0000_0000_0000_0001,  2'd2}, // R6
    '{3'd0, 1'b0, 1'b1, 64'h4004, PR,                       2'd2}, // R6
    '{3'd1, 1'b0, 1'b1, 64'h4008, PR,                       2'd1}, // R6 precedence
    '{3'd5, 1'b0, 1'b0, 64'h5000, PR,                       2'd1}, // R2 attention in problem state
    '{3'd2, 1'b0, 1'b0, 64'h5004, 64'hFFFF_FFFF_FFFF_FFFF,  2'd1}  // R7
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_class_i = '0;
  logic        spr_msb_i = 1'b0;
  logic        illegal_i = 1'b0;
  logic [63:0] cia_i = '0;
  logic [63:0] msr_i = '0;
  logic [63:0] nia_o, srr0_o, srr1_o, msr_o;
  logic        trap_o, halted_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] e_nia = '0, e_srr0 = '0, e_srr1 = '0, e_msr = '0;

  always #10 clk_i = ~clk_i;

  priv_trap_unit u_priv_trap_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_class_i(op_class_i),
    .spr_msb_i(spr_msb_i), .illegal_i(illegal_i), .cia_i(cia_i), .msr_i(msr_i),
    .nia_o(nia_o), .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o),
    .trap_o(trap_o), .halted_o(halted_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic msb, input logic ill,
                       input logic [63:0] cia, input logic [63:0] msr);
    @(negedge clk_i);
    op_class_i = op; spr_msb_i = msb; illegal_i = ill; cia_i = cia; msr_i = msr;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic check_all(input string tag, input logic exp_trap);
    chk({tag, " trap"}, {63'd0, trap_o}, {63'd0, exp_trap});
    chk({tag, " nia"}, nia_o, e_nia);
    chk({tag, " srr0"}, srr0_o, e_srr0);
    chk({tag, " srr1"}, srr1_o, e_srr1);
    chk({tag, " msr"}, msr_o, e_msr);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check_all("R1", 1'b0);
    chk("R1 halted", {63'd0, halted_o}, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      apply(v.op, v.msb, v.ill, v.cia, v.msr);
      if (v.kind != 2'd0) begin
        e_srr0 = v.cia;
        e_srr1 = v.msr | ((v.kind == 2'd1) ? 64'h4_0000 : 64'h8_0000);
        e_msr  = (v.msr & ~CLRM) | SETM;
        e_nia  = 64'h700;
      end else begin
        e_msr = v.msr;
        e_nia = v.cia + 64'd4;
      end
      check_all($sformatf("R2/R3/R4/R5/R6/R7/R9 vec%0d", i), v.kind != 2'd0);
    end

    // R10: trapping inputs with valid low
    @(negedge clk_i);
    op_class_i = 3'd1; illegal_i = 1'b1; cia_i = 64'h9000; msr_i = PR;
    repeat (3) @(negedge clk_i);
    check_all("R10 idle", 1'b0);

    // R8: supervisor attention halts, later instructions ignored
    apply(3'd5, 1'b0, 1'b0, 64'h6000, 64'h0);
    check_all("R8 halt", 1'b0);
    chk("R8 halted", {63'd0, halted_o}, 64'd1);
    apply(3'd1, 1'b0, 1'b0, 64'h6004, PR);
    check_all("R8 frozen trap", 1'b0);
    apply(3'd0, 1'b0, 1'b0, 64'h6008, 64'h0);
    check_all("R8 frozen exec", 1'b0);
    chk("R8 still halted", {63'd0, halted_o}, 64'd1);

    // R1 reset clears halt
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    e_nia = '0; e_srr0 = '0; e_srr1 = '0; e_msr = '0;
    check_all("R1 rereset", 1'b0);
    chk("R1 halt cleared", {63'd0, halted_o}, 64'd0);
    rst_ni = 1'b1;
    apply(3'd0, 1'b0, 1'b0, 64'h7000, 64'h10);
    e_nia = 64'h7004; e_msr = 64'h10;
    check_all("R9 after reset", 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule